// File: doc/BRIEF.md
# Match-Triggered Watchdog Reset Controller

This peripheral is a watchdog that sits on a simple word-addressed register bus. A free-running up-counter advances once per `tick` strobe from an external rate generator. One compare register is checked against it. When the counter equals the compare value on a counting tick, the block can do several things in that same tick. It can set an interrupt flag, halt the counter, update a match output pin, hold the internal reset request high, and start an external reset pulse whose length software programs. Each of these actions has its own enable.

Software can also force either reset output high directly. A counter clear request completes a fixed number of ticks after it is written, so software polls the counter until it reads zero. A sticky cause bit records that one of the reset outputs was driven. Only the power-on reset clears that bit. The system reset that the block itself requests does not clear it.

The register window is eight words, selected by the word address `bus_addr`:
- 0: interrupt flag
- 1: control
- 2: counter
- 3: action enables
- 4: compare value
- 5: match pin
- 6: pulse length
- 7: cause

Top module: `wdg_match_rst`

## Requirements
- R1: After power-on reset, every register reads 0, and `irq`, `match_out`, `int_rst` and `ext_rst` are low.
- R2: While control bit 0 (word 1) is set and no clear is pending, the counter (word 2) increases by exactly one on each cycle with `tick` high. It holds on cycles with `tick` low. Writes to word 2 are ignored.
- R3: While control bit 2 is set and `dbg_halt` is high, the counter does not advance. With control bit 2 clear, `dbg_halt` has no effect.
- R4: Writing control bit 1 starts a clear. The counter freezes at its old value, reads 0 after the second following tick, and control bit 1 reads 1 until then and 0 afterwards.
- R5: When the counter equals the compare value (word 4) on a counting tick and action bit 0 (word 3) is set, the interrupt flag (word 0, bit 0) and `irq` go high. Writing 1 to word 0 bit 0 clears them. With action bit 0 clear, no flag is raised.
- R6: With action bit 2 set, a match leaves the counter at the compare value and clears control bit 0.
- R7: Word 5 bit 0 is the `match_out` level, and software can write it. On a match, bits 5:4 select the change: 0 none, 1 drive low, 2 drive high, 3 toggle.
- R8: With action bit 3 set, a match drives `int_rst` high. It stays high until `sys_rst_n` is pulsed.
- R9: With action bit 4 set, a match drives `ext_rst` high for (word 6 bits 15:0) + 6 ticks.
- R10: Action bit 5 drives `int_rst` high and action bit 6 drives `ext_rst` high, starting in the cycle after the write and lasting for as long as the bit is set.
- R11: Cause bit (word 7, bit 0) is set whenever `int_rst` or `ext_rst` is high. Writes to it are ignored. It survives `sys_rst_n` and is cleared only by `por_n`.
- R12: Writing 0 to the control register stops the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | Synchronous system reset, active low, clears all but the cause bit |
| tick | input | 1 | Count-rate strobe, one cycle per tick |
| dbg_halt | input | 1 | Debugger halt indication |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Match interrupt flag |
| match_out | output | 1 | Match pin level |
| int_rst | output | 1 | Internal reset request |
| ext_rst | output | 1 | External reset output |

## Verification
The embedded properties guard the following on every cycle:
- the counter holds without a tick or while halted;
- the counter reads zero the moment a pending clear retires;
- the counter and run bit freeze after a stopping match;
- the interrupt flag and the drive-high pin action follow a match;
- the pulse counter steps down once per tick;
- the internal reset request and the cause bit are sticky.

Only the bench scenarios show the end-to-end counts: the exact tick at which a compare value fires, the measured width of each external reset pulse, the toggle and drive-low pin actions, that forced resets hold exactly as long as their bit, and which state survives a system reset versus a power-on reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // register word indices
   localparam int unsigned W_IRQ   = 0;
   localparam int unsigned W_CTRL  = 1;
   localparam int unsigned W_CNT   = 2;
   localparam int unsigned W_ACT   = 3;
   localparam int unsigned W_CMP   = 4;
   localparam int unsigned W_PIN   = 5;
   localparam int unsigned W_PLEN  = 6;
   localparam int unsigned W_CAUSE = 7;

   // control bits
   localparam int unsigned C_RUN   = 0;
   localparam int unsigned C_CLR   = 1;
   localparam int unsigned C_DBG   = 2;

   // action-enable bits
   localparam int unsigned A_IRQ   = 0;
   localparam int unsigned A_STOP  = 2;
   localparam int unsigned A_INT   = 3;
   localparam int unsigned A_EXT   = 4;
   localparam int unsigned A_FINT  = 5;
   localparam int unsigned A_FEXT  = 6;
   localparam int unsigned ACT_W   = 7;
   localparam logic [ACT_W-1:0] ACT_MASK = 7'b111_1101;

   typedef enum logic [1:0] {
      PIN_KEEP   = 2'd0,
      PIN_LOW    = 2'd1,
      PIN_HIGH   = 2'd2,
      PIN_TOGGLE = 2'd3
   } pin_act_e;
endpackage

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int CNT_W     = 32,
   parameter int CLR_DELAY = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sys_rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             dbg_stop,
   input  logic             dbg_halt,
   input  logic             clr_start,
   input  logic             stop_en,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] cnt,
   output logic             clr_pend,
   output logic             hit
);
   localparam int DW = (CLR_DELAY < 2) ? 1 : $clog2(CLR_DELAY + 1);

   logic go;
   logic clr_now;

   assign go  = run && !(dbg_stop && dbg_halt) && !clr_pend;
   assign hit = tick && go && (cnt == cmp_val);

   generate
      if (CLR_DELAY == 0) begin : g_clr_direct
         assign clr_pend = 1'b0;
         assign clr_now  = clr_start;
      end else begin : g_clr_delayed
         logic [DW-1:0] clr_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                    clr_q <= '0;
            else if (!sys_rst_n)           clr_q <= '0;
            else if (clr_start)            clr_q <= DW'(CLR_DELAY);
            else if (tick && clr_q != '0)  clr_q <= clr_q - DW'(1);
         end
         assign clr_pend = (clr_q != '0);
         assign clr_now  = tick && (clr_q == DW'(1));
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                              cnt <= '0;
      else if (!sys_rst_n)                     cnt <= '0;
      else if (clr_now)                        cnt <= '0;
      else if (tick && go && !(hit && stop_en)) cnt <= cnt + CNT_W'(1);
   end

   assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (!tick && !clr_start) |=> $stable(cnt));
   assert_debug_freeze_R3: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (dbg_stop && dbg_halt && !clr_pend && !clr_start) |=> $stable(cnt));
   assert_clear_done_R4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      $fell(clr_pend) |-> (cnt == '0));
   assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (hit && stop_en && !clr_start) |=> $stable(cnt));
endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
   parameter int LEN_W = 16,
   parameter int EXTRA = 6
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sys_rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   output logic             busy
);
   localparam int PW = LEN_W + 1;

   logic [PW-1:0] pcnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                    pcnt <= '0;
      else if (!sys_rst_n)           pcnt <= '0;
      else if (start)                pcnt <= PW'(len) + PW'(EXTRA);
      else if (tick && pcnt != '0)   pcnt <= pcnt - PW'(1);
   end

   assign busy = (pcnt != '0);

   assert_pulse_step_R9: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (busy && tick && !start) |=> (pcnt == $past(pcnt) - PW'(1)));
   assert_pulse_hold_R9: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (!tick && !start) |=> $stable(pcnt));
endmodule

// File: rtl/wdg_match_pin.sv
module wdg_match_pin
   import wdg_pkg::*;
(
   input  logic     clk,
   input  logic     por_n,
   input  logic     sys_rst_n,
   input  logic     wr,
   input  logic     wr_level,
   input  logic [1:0] wr_act,
   input  logic     hit,
   output logic     level,
   output pin_act_e act
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         level <= 1'b0;
         act   <= PIN_KEEP;
      end else if (!sys_rst_n) begin
         level <= 1'b0;
         act   <= PIN_KEEP;
      end else if (wr) begin
         level <= wr_level;
         act   <= pin_act_e'(wr_act);
      end else if (hit) begin
         case (act)
            PIN_LOW:    level <= 1'b0;
            PIN_HIGH:   level <= 1'b1;
            PIN_TOGGLE: level <= !level;
            default:    level <= level;
         endcase
      end
   end

   assert_pin_high_R7: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (hit && !wr && act == PIN_HIGH) |=> level);
   assert_pin_keep_R7: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (!wr && act == PIN_KEEP) |=> $stable(level));
endmodule

// File: rtl/wdg_match_rst.sv
module wdg_match_rst
   import wdg_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 32,
   parameter int LEN_W       = 16,
   parameter int AW          = 3,
   parameter int PULSE_EXTRA = 6,
   parameter int CLR_DELAY   = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              tick,
   input  logic              dbg_halt,
   input  logic [AW-1:0]     bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              match_out,
   output logic              int_rst,
   output logic              ext_rst
);
   generate
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("counter wider than data bus");
      end
      if (LEN_W > DATA_W || LEN_W < 1) begin : g_bad_len
         $error("pulse length width out of range");
      end
      if (AW < 3) begin : g_bad_aw
         $error("address too narrow for eight registers");
      end
      if (CLR_DELAY > 7 || CLR_DELAY < 0) begin : g_bad_clr
         $error("clear delay out of range");
      end
   endgenerate

   logic              run_q, dbg_q, irq_q, int_hold, cause_q;
   logic [ACT_W-1:0]  act_q;
   logic [CNT_W-1:0]  cmp_q;
   logic [LEN_W-1:0]  plen_q;
   logic [CNT_W-1:0]  cnt;
   logic              clr_pend, hit, pulse_busy;
   pin_act_e          pin_act;

   logic wr_irq, wr_ctrl, wr_act, wr_cmp, wr_pin, wr_plen;
   assign wr_irq  = bus_we && (bus_addr == AW'(W_IRQ));
   assign wr_ctrl = bus_we && (bus_addr == AW'(W_CTRL));
   assign wr_act  = bus_we && (bus_addr == AW'(W_ACT));
   assign wr_cmp  = bus_we && (bus_addr == AW'(W_CMP));
   assign wr_pin  = bus_we && (bus_addr == AW'(W_PIN));
   assign wr_plen = bus_we && (bus_addr == AW'(W_PLEN));

   // control and configuration registers
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n || !sys_rst_n) begin
         run_q  <= 1'b0;
         dbg_q  <= 1'b0;
         act_q  <= '0;
         cmp_q  <= '0;
         plen_q <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q <= bus_wdata[C_RUN];
            dbg_q <= bus_wdata[C_DBG];
         end else if (hit && act_q[A_STOP]) begin
            run_q <= 1'b0;
         end
         if (wr_act)  act_q  <= bus_wdata[ACT_W-1:0] & ACT_MASK;
         if (wr_cmp)  cmp_q  <= bus_wdata[CNT_W-1:0];
         if (wr_plen) plen_q <= bus_wdata[LEN_W-1:0];
      end
   end

   // interrupt flag and latched internal reset request
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n || !sys_rst_n) begin
         irq_q    <= 1'b0;
         int_hold <= 1'b0;
      end else begin
         if (hit && act_q[A_IRQ])       irq_q <= 1'b1;
         else if (wr_irq && bus_wdata[0]) irq_q <= 1'b0;
         if (hit && act_q[A_INT])       int_hold <= 1'b1;
      end
   end

   // cause bit: only power-on clears it
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  cause_q <= 1'b0;
      else if (int_rst || ext_rst) cause_q <= 1'b1;
   end

   wdg_counter #(.CNT_W(CNT_W), .CLR_DELAY(CLR_DELAY)) u_cnt (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .tick      (tick),
      .run       (run_q),
      .dbg_stop  (dbg_q),
      .dbg_halt  (dbg_halt),
      .clr_start (wr_ctrl && bus_wdata[C_CLR]),
      .stop_en   (act_q[A_STOP]),
      .cmp_val   (cmp_q),
      .cnt       (cnt),
      .clr_pend  (clr_pend),
      .hit       (hit)
   );

   wdg_rst_pulse #(.LEN_W(LEN_W), .EXTRA(PULSE_EXTRA)) u_pulse (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .tick      (tick),
      .start     (hit && act_q[A_EXT]),
      .len       (plen_q),
      .busy      (pulse_busy)
   );

   wdg_match_pin u_pin (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .wr        (wr_pin),
      .wr_level  (bus_wdata[0]),
      .wr_act    (bus_wdata[5:4]),
      .hit       (hit),
      .level     (match_out),
      .act       (pin_act)
   );

   assign irq     = irq_q;
   assign int_rst = int_hold || act_q[A_FINT];
   assign ext_rst = pulse_busy || act_q[A_FEXT];

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         AW'(W_IRQ):   bus_rdata[0] = irq_q;
         AW'(W_CTRL): begin
            bus_rdata[C_RUN] = run_q;
            bus_rdata[C_CLR] = clr_pend;
            bus_rdata[C_DBG] = dbg_q;
         end
         AW'(W_CNT):   bus_rdata = DATA_W'(cnt);
         AW'(W_ACT):   bus_rdata = DATA_W'(act_q);
         AW'(W_CMP):   bus_rdata = DATA_W'(cmp_q);
         AW'(W_PIN): begin
            bus_rdata[0]   = match_out;
            bus_rdata[5:4] = pin_act;
         end
         AW'(W_PLEN):  bus_rdata = DATA_W'(plen_q);
         AW'(W_CAUSE): bus_rdata[0] = cause_q;
         default:      bus_rdata = '0;
      endcase
   end

   assert_irq_on_match_R5: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (hit && act_q[A_IRQ]) |=> irq);
   assert_stop_clears_run_R6: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (hit && act_q[A_STOP] && !wr_ctrl) |=> !run_q);
   assert_int_sticky_R8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      int_hold |=> int_hold);
   assert_cause_set_R11: assert property (@(posedge clk) disable iff (!por_n)
      (int_rst || ext_rst) |=> cause_q);
   assert_cause_sticky_R11: assert property (@(posedge clk) disable iff (!por_n)
      cause_q |=> cause_q);
endmodule

// File: tb/wdg_match_rst_test.sv
module wdg_match_rst_test;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sys_rst_n = 1'b1;
   logic        tick = 1'b0;
   logic        dbg_halt = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, match_out, int_rst, ext_rst;

   int n_chk = 0;
   int n_fail = 0;
   int exp_pulse[$];
   int hi_run = 0;

   always #4 clk = !clk;

   wdg_match_rst uut (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick),
      .dbg_halt(dbg_halt), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .match_out(match_out), .int_rst(int_rst), .ext_rst(ext_rst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: measures each ext_rst pulse width and pops its expectation
   always @(negedge clk) begin
      if (ext_rst === 1'b1) hi_run++;
      else if (hi_run != 0) begin
         if (exp_pulse.size() == 0) chk("R9/R10 unexpected ext_rst pulse", hi_run, 0);
         else chk("R9/R10 ext_rst width", hi_run, exp_pulse.pop_front());
         hi_run = 0;
      end
   end

   task automatic wr(input int idx, input logic [31:0] d);
      bus_addr = idx[2:0]; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int idx, input logic [31:0] exp, input string req);
      bus_addr = idx[2:0];
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic ticks(input int n);
      tick = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sys_pulse();
      sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1;
   endtask

   task automatic por_pulse();
      por_n = 1'b0; @(negedge clk); por_n = 1'b1;
   endtask

   task automatic run_to(input int m);
      wr(4, m); wr(1, 2); ticks(2); wr(1, 1); ticks(m + 1);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      idle(3);
      por_n = 1'b1;
      idle(1);
      // R1 reset state
      for (int i = 0; i < 8; i++) rd(i, 0, "R1 register reset value");
      chk("R1 outputs low", {irq, match_out, int_rst, ext_rst}, 0);

      // R2 counting per tick, ignoring writes to the counter
      wr(1, 1);
      idle(2); rd(2, 0, "R2 no tick no count");
      ticks(5); rd(2, 5, "R2 five ticks");
      idle(3); rd(2, 5, "R2 hold without tick");
      wr(2, 32'h55); rd(2, 5, "R2 counter write ignored");

      // R3 debug halt
      wr(1, 5); dbg_halt = 1'b1;
      ticks(4); rd(2, 5, "R3 halted");
      dbg_halt = 1'b0; ticks(2); rd(2, 7, "R3 resumed");
      wr(1, 1); dbg_halt = 1'b1;
      ticks(1); rd(2, 8, "R3 halt ignored when disabled");
      dbg_halt = 1'b0;

      // R4 delayed clear
      wr(1, 3);
      rd(2, 8, "R4 old value while pending"); rd(1, 3, "R4 pending bit set");
      ticks(1); rd(2, 8, "R4 still pending after one tick");
      ticks(1); rd(2, 0, "R4 zero after two ticks"); rd(1, 1, "R4 pending bit self-clears");
      ticks(3); rd(2, 3, "R4 counts after clear");

      // R12 stop by writing zero
      wr(1, 0); ticks(4); rd(2, 3, "R12 stopped");

      // R5 interrupt on match
      wr(3, 1);
      wr(4, 10); wr(1, 2); ticks(2); wr(1, 1);
      ticks(10); rd(2, 10, "R5 reached compare"); chk("R5 no irq before match tick", irq, 0);
      ticks(1); chk("R5 irq on match", irq, 1); rd(0, 1, "R5 flag reads 1");
      rd(2, 11, "R5 counts on without stop");
      wr(0, 1); chk("R5 irq cleared", irq, 0); rd(0, 0, "R5 flag cleared");
      wr(1, 0);

      // R6 stop on match (irq disabled)
      wr(3, 4);
      wr(4, 4); wr(1, 2); ticks(2); wr(1, 1); ticks(10);
      rd(2, 4, "R6 held at compare"); rd(1, 0, "R6 run cleared");
      chk("R5 no irq when disabled", irq, 0);

      // R7 match pin actions
      wr(3, 0); wr(5, 32'h20);
      chk("R7 pin low", match_out, 0);
      run_to(3); chk("R7 drive high", match_out, 1); rd(5, 32'h21, "R7 pin readback");
      wr(1, 0); wr(5, 32'h31);
      run_to(3); chk("R7 toggle", match_out, 0); wr(1, 0);
      wr(5, 32'h11); chk("R7 software level", match_out, 1);
      run_to(3); chk("R7 drive low", match_out, 0); wr(1, 0);
      wr(5, 32'h01); run_to(3); chk("R7 no action", match_out, 1); wr(1, 0);

      // R9 external pulse on match
      wr(6, 5); rd(6, 5, "R9 length readback");
      wr(4, 2); wr(1, 2); ticks(2); wr(3, 32'h10);
      exp_pulse.push_back(11);
      wr(1, 1); ticks(30); wr(1, 0);
      chk("R9 pulse ended", ext_rst, 0); chk("R9 no internal reset", int_rst, 0);

      // R11 cause bit
      rd(7, 1, "R11 cause set by pulse");
      wr(7, 0); rd(7, 1, "R11 write ignored");
      sys_pulse();
      rd(3, 0, "R11 sys reset clears actions"); rd(6, 0, "R11 sys reset clears length");
      rd(7, 1, "R11 survives sys reset");
      por_pulse(); rd(7, 0, "R11 cleared by power-on");

      // R8 internal reset on match
      wr(3, 8); run_to(1);
      chk("R8 int_rst set", int_rst, 1);
      wr(1, 0); idle(5); chk("R8 int_rst held", int_rst, 1);
      chk("R8 ext_rst unaffected", ext_rst, 0); rd(7, 1, "R11 cause from int_rst");
      sys_pulse(); chk("R8 released by sys reset", int_rst, 0);
      por_pulse();

      // R10 forced outputs
      wr(3, 32'h20); chk("R10 forced int_rst", int_rst, 1);
      wr(3, 0); chk("R10 int_rst released", int_rst, 0); rd(7, 1, "R11 cause from force");
      exp_pulse.push_back(7);
      wr(3, 32'h40); chk("R10 forced ext_rst", ext_rst, 1);
      idle(6); wr(3, 0);
      idle(3); chk("R10 ext_rst released", ext_rst, 0);
      chk("R9/R10 all pulses seen", exp_pulse.size(), 0);
      report();
   end
endmodule